// File: doc/BRIEF.md
# Serial Configuration Front End for a Two-Channel Programmable Delay

This block takes a three-wire serial programming stream (data, shift clock, load strobe) plus an output-enable input, all asynchronous to the chip, and turns it into configuration state for a two-channel delay line. Each programming pass shifts an 11-bit word into a shift register. The word carries a channel-select bit, a mode bit and a 9-bit delay code. While the load strobe is high, the channel named by the select bit follows the shift register. When the strobe drops, that channel is frozen.

All four serial-side inputs are brought into the system clock domain through two-flop synchronisers. Edges of the shift clock are then detected on the synchronised copy. The block outputs the two stored 9-bit delay codes and the stored mode bit. It also outputs a mask flag, which tells the downstream output stage to force its true output low and its complement high while the enable input is high. Programming works the same whatever the enable input is doing.

Top module: `dly_cfg_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, both channel codes and `mode_sel_o` read zero after that edge, and `out_mask_o` reads 0.
- R2: The shift register moves by one bit for each rising edge of `ser_clk_i` and by no bit otherwise. The bit sampled at a rising edge enters the least significant end. The first bit of an 11-bit pass therefore ends in bit 10 (channel select), the second in bit 9 (mode), and the remaining nine bits form the code, most significant first.
- R3: A load with select bit 0 writes the code to `chan0_code_o` and leaves `chan1_code_o` unchanged.
- R4: A load with select bit 1 writes the code to `chan1_code_o` and leaves `chan0_code_o` unchanged.
- R5: `mode_sel_o` takes the value of bit 9 of the word present while the latch is open, for a load to either channel.
- R6: While `ser_load_i` stays high, each further shift is passed through at once to the channel that the updated select bit names.
- R7: When `ser_load_i` is low, activity on `ser_clk_i` and `ser_data_i` changes neither channel code nor `mode_sel_o`.
- R8: When `ser_load_i` and `ser_clk_i` rise in the same cycle, the latch shows the post-shift word in the very first cycle it is open. This happens 3 clock edges after the inputs change.
- R9: `out_mask_o` equals the value `mask_req_i` had two clock edges earlier. A high level on `mask_req_i` does not stop programming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_data_i | input | 1 | Serial data, sampled on shift-clock rising edges |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous) |
| ser_load_i | input | 1 | Load strobe; latch is transparent while high |
| mask_req_i | input | 1 | High requests masked outputs |
| chan0_code_o | output | 9 | Stored delay code of channel 0 |
| chan1_code_o | output | 9 | Stored delay code of channel 1 |
| mode_sel_o | output | 1 | Stored mode bit |
| out_mask_o | output | 1 | Synchronised mask flag for the output stage |

## Verification
A shift register that is out by one position shows up on the next load as a code shifted by one bit, and usually as a swapped channel, because the select bit then comes from a different position. A latch that leaks while closed changes a code within three cycles of a shift-clock edge with the strobe low. The bench looks for this at the ports after a full burst of shifts. A wrong ordering between shift and latch open can only be seen in the first cycle the latch is open, so that cycle is sampled exactly. Mask latency errors show up as a one-cycle early or late flag.

// File: rtl/dly_cfg_pkg.sv
// Package: shared constants for the serial delay-configuration front end.
// Assumes exactly two delay channels addressed by one select bit.
package dly_cfg_pkg;
    localparam int CODE_W      = 9;                       // delay code width
    localparam int NUM_CH      = 2;                       // number of channels
    localparam int SEL_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int WORD_W      = SEL_W + 1 + CODE_W;      // select + mode + code
    localparam int SYNC_STAGES = 2;                       // synchroniser depth

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/dly_cfg_sync.sv
// Module: bank of multi-flop synchronisers, one chain per input bit.
// Assumes inputs are asynchronous levels that stay stable for several clocks.
module dly_cfg_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage samples the raw asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_i;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            // Each later stage resamples the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/dly_cfg_shifter.sv
// Module: shift-clock edge detector and serial-in shift register.
// Assumes shift clock and data arrive already synchronised with equal latency.
module dly_cfg_shifter #(
    parameter int WORD_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              sdin_i,
    output logic              sclk_rise_o,
    output logic [WORD_W-1:0] shreg_o,
    output logic [WORD_W-1:0] shreg_next_o
);
    logic sclk_q;

    // Remember the previous shift-clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_i;
    end

    // A rising edge is a high level now that was low one cycle earlier.
    assign sclk_rise_o = sclk_i & ~sclk_q;

    // Next content: one position towards the MSB with new data at bit 0.
    always_comb begin
        if (sclk_rise_o) shreg_next_o = {shreg_o[WORD_W-2:0], sdin_i};
        else             shreg_next_o = shreg_o;
    end

    // Register the shift register content.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg_o <= '0;
        else        shreg_o <= shreg_next_o;
    end
endmodule

// File: rtl/dly_cfg_latch.sv
// Module: per-channel code latches and shared mode bit, open while load is high.
// Assumes the word input already includes any shift of the current cycle.
module dly_cfg_latch #(
    parameter int NUM_CH = 2,
    parameter int SEL_W  = 1,
    parameter int CODE_W = 9,
    localparam int WORD_W = SEL_W + 1 + CODE_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           open_i,
    input  logic [WORD_W-1:0]              word_i,
    output logic [NUM_CH-1:0][CODE_W-1:0]  code_o,
    output logic                           mode_o
);
    logic [SEL_W-1:0]  sel;
    logic              mode_bit;
    logic [CODE_W-1:0] code_bits;

    // Split the word into select, mode and code fields.
    assign sel       = word_i[WORD_W-1 -: SEL_W];
    assign mode_bit  = word_i[CODE_W];
    assign code_bits = word_i[CODE_W-1:0];

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
            // Channel follows the word while open and addressed.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    code_o[ch] <= '0;
                else if (open_i && (sel == SEL_W'(ch)))
                    code_o[ch] <= code_bits;
            end
        end
    endgenerate

    // Mode bit follows the word while the latch is open.
    always_ff @(posedge clk) begin
        if (!rst_n)      mode_o <= 1'b0;
        else if (open_i) mode_o <= mode_bit;
    end
endmodule

// File: rtl/dly_cfg_top.sv
// Module: serial configuration front end for a two-channel programmable delay.
// Assumes all serial-side inputs are asynchronous and slow against clk.
module dly_cfg_top
    import dly_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_data_i,
    input  logic              ser_clk_i,
    input  logic              ser_load_i,
    input  logic              mask_req_i,
    output logic [CODE_W-1:0] chan0_code_o,
    output logic [CODE_W-1:0] chan1_code_o,
    output logic              mode_sel_o,
    output logic              out_mask_o
);
    logic [3:0]                     sync_v;
    logic                           sdin_s;
    logic                           sclk_s;
    logic                           sload_s;
    logic                           sclk_rise;
    word_t                          shreg;
    word_t                          shreg_next;
    logic [NUM_CH-1:0][CODE_W-1:0]  codes;

    // Bring all serial-side inputs into the clock domain.
    dly_cfg_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({mask_req_i, ser_load_i, ser_clk_i, ser_data_i}),
        .sync_o  (sync_v)
    );

    assign sdin_s     = sync_v[0];
    assign sclk_s     = sync_v[1];
    assign sload_s    = sync_v[2];
    assign out_mask_o = sync_v[3];

    dly_cfg_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .sclk_i       (sclk_s),
        .sdin_i       (sdin_s),
        .sclk_rise_o  (sclk_rise),
        .shreg_o      (shreg),
        .shreg_next_o (shreg_next)
    );

    dly_cfg_latch #(.NUM_CH(NUM_CH), .SEL_W(SEL_W), .CODE_W(CODE_W)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .open_i (sload_s),
        .word_i (shreg_next),
        .code_o (codes),
        .mode_o (mode_sel_o)
    );

    assign chan0_code_o = codes[0];
    assign chan1_code_o = codes[1];
endmodule

// File: rtl/dly_cfg_chk.sv
// Checker: temporal properties of the configuration front end, bound to the top.
module dly_cfg_chk
    import dly_cfg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sclk_rise,
    input logic              sload_s,
    input logic              mask_req_i,
    input logic [WORD_W-1:0] shreg,
    input logic [CODE_W-1:0] chan0_code_o,
    input logic [CODE_W-1:0] chan1_code_o,
    input logic              mode_sel_o,
    input logic              out_mask_o
);
    // R1: reset clears the stored state
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (chan0_code_o == '0 && chan1_code_o == '0 && !mode_sel_o && !out_mask_o));

    // R2: one position per detected edge
    a_r2_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise |=> shreg[WORD_W-1:1] == $past(shreg[WORD_W-2:0]));

    // R2: no movement without an edge
    a_r2_shift_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_rise |=> $stable(shreg));

    // R7: closed latch keeps all stored values
    a_r7_closed_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !sload_s |=> ($stable(chan0_code_o) && $stable(chan1_code_o) && $stable(mode_sel_o)));

    // R3: at most one channel changes per cycle
    a_r3_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $countones({chan0_code_o != $past(chan0_code_o),
                                     chan1_code_o != $past(chan1_code_o)}) <= 1);

    // R9: mask tracks the request two edges later
    a_r9_mask_delay: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> out_mask_o == $past(mask_req_i, 2));
endmodule

bind dly_cfg_top dly_cfg_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sclk_rise    (sclk_rise),
    .sload_s      (sload_s),
    .mask_req_i   (mask_req_i),
    .shreg        (shreg),
    .chan0_code_o (chan0_code_o),
    .chan1_code_o (chan1_code_o),
    .mode_sel_o   (mode_sel_o),
    .out_mask_o   (out_mask_o)
);

// File: tb/tb_dly_cfg_top.sv
`timescale 1ns/1ps
module tb_dly_cfg_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sdin = 1'b0, sclk = 1'b0, sload = 1'b0, en = 1'b0;
    logic [8:0] ch0, ch1;
    logic       mode, mask;

    int         n_checks = 0;
    int         n_errors = 0;
    bit         done = 1'b0;

    // Bench model: shift register, channel codes, mode bit
    logic [10:0] m_sr = '0;
    logic [8:0]  m_code [2] = '{9'h0, 9'h0};
    logic        m_mode = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    dly_cfg_top dut (
        .clk(clk), .rst_n(rst_n), .ser_data_i(sdin), .ser_clk_i(sclk),
        .ser_load_i(sload), .mask_req_i(en),
        .chan0_code_o(ch0), .chan1_code_o(ch1),
        .mode_sel_o(mode), .out_mask_o(mask)
    );

    // {en, sel, mode, code, exp_ch0, exp_ch1, exp_mode}
    localparam logic [30:0] VEC [6] = '{
        {1'b0, 1'b0, 1'b1, 9'h1A5, 9'h1A5, 9'h000, 1'b1},
        {1'b0, 1'b1, 1'b0, 9'h0FF, 9'h1A5, 9'h0FF, 1'b0},
        {1'b1, 1'b0, 1'b0, 9'h000, 9'h000, 9'h0FF, 1'b0},
        {1'b1, 1'b1, 1'b1, 9'h1FF, 9'h000, 9'h1FF, 1'b1},
        {1'b0, 1'b0, 1'b1, 9'h155, 9'h155, 9'h1FF, 1'b1},
        {1'b0, 1'b1, 1'b0, 9'h0AA, 9'h155, 9'h0AA, 1'b0}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic model_latch();
        m_code[m_sr[10]] = m_sr[8:0];
        m_mode = m_sr[9];
    endtask

    // One serial bit: data set with clock low, then clock high
    task automatic put_bit(input logic b);
        sdin = b; sclk = 1'b0;
        wait_n(3);
        sclk = 1'b1;
        m_sr = {m_sr[9:0], b};
        if (sload) model_latch();
        wait_n(3);
        sclk = 1'b0;
    endtask

    task automatic shift_word(input logic [10:0] w);
        for (int i = 10; i >= 0; i--) put_bit(w[i]);
    endtask

    task automatic pulse_load(input bit keep_open);
        sload = 1'b1;
        model_latch();
        wait_n(4);
        if (!keep_open) begin
            sload = 1'b0;
            wait_n(4);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        en = 1'b1;
        wait_n(5);
        check("R1 ch0 reset", 16'(ch0), 16'h0);
        check("R1 ch1 reset", 16'(ch1), 16'h0);
        check("R1 mode reset", 16'(mode), 16'h0);
        check("R1 mask reset", 16'(mask), 16'h0);
        en = 1'b0;
        rst_n = 1'b1;
        wait_n(3);

        // Table walk: R2 R3 R4 R5 R9 (programming with en high too)
        for (int i = 0; i < 6; i++) begin
            logic [30:0] v;
            v = VEC[i];
            en = v[30];
            shift_word(v[29:19]);
            pulse_load(1'b0);
            check($sformatf("R3/R2 vec%0d ch0", i), 16'(ch0), 16'(v[18:10]));
            check($sformatf("R4/R2 vec%0d ch1", i), 16'(ch1), 16'(v[9:1]));
            check($sformatf("R5 vec%0d mode", i), 16'(mode), 16'(v[0]));
            check($sformatf("R9 vec%0d mask", i), 16'(mask), 16'(v[30]));
        end

        // R7: closed latch ignores a full burst of shifts
        shift_word(11'h7FF);
        wait_n(4);
        check("R7 ch0 frozen", 16'(ch0), 16'h155);
        check("R7 ch1 frozen", 16'(ch1), 16'h0AA);
        check("R7 mode frozen", 16'(mode), 16'h0);

        // R6: transparency while load stays high
        shift_word({1'b0, 1'b1, 9'h0C3});
        pulse_load(1'b1);
        check("R6 ch0 open", 16'(ch0), 16'h0C3);
        put_bit(1'b1);
        wait_n(3);
        check("R6 ch0 after pass", 16'(ch0), 16'(m_code[0]));
        check("R6 ch1 after pass", 16'(ch1), 16'(m_code[1]));
        check("R6 mode after pass", 16'(mode), 16'(m_mode));
        sload = 1'b0;
        wait_n(4);

        // R8: load and shift clock rise together
        begin
            logic [10:0] w;
            w = {1'b1, 1'b1, 9'h13C};
            for (int i = 10; i >= 1; i--) put_bit(w[i]);
            sdin = w[0]; sclk = 1'b0;
            wait_n(3);
            sclk = 1'b1; sload = 1'b1;
            m_sr = {m_sr[9:0], w[0]};
            model_latch();
            wait_n(3);
            check("R8 ch1 first open cycle", 16'(ch1), 16'h13C);
            check("R8 mode first open cycle", 16'(mode), 16'h1);
            sload = 1'b0; sclk = 1'b0;
            wait_n(4);
            check("R8 ch0 untouched", 16'(ch0), 16'(m_code[0]));
        end

        // R9: mask latency of exactly two edges
        en = 1'b1;
        @(negedge clk);
        check("R9 mask after one edge", 16'(mask), 16'h0);
        @(negedge clk);
        check("R9 mask after two edges", 16'(mask), 16'h1);
        en = 1'b0;
        wait_n(2);
        check("R9 mask released", 16'(mask), 16'h0);

        // R1: reset in mid-run clears loaded codes
        rst_n = 1'b0;
        wait_n(2);
        check("R1 ch0 rerun", 16'(ch0), 16'h0);
        check("R1 ch1 rerun", 16'(ch1), 16'h0);
        check("R1 mode rerun", 16'(mode), 16'h0);
        rst_n = 1'b1;
        wait_n(3);

        finish_run();
    end
endmodule